// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is a three-stage multiply-accumulate engine that sits behind a simple issue port. Each accepted operation multiplies two operands and either adds the product into a 32-bit accumulator or loads the product into it. Halfword operations are 16x16 and can issue on every clock. Full-word operations are 32x32, keep the low 32 bits of the product, and hold the issue port closed for three cycles while one shared 16x16 multiplier forms the three partial products that the low word needs.

Halfword operands come from the low 16 bits of each operand input. They are read as signed integers, as unsigned integers, or as signed Q1.15 fractions. A fractional product is doubled into Q1.31 and is clamped when both inputs are -1.0. Fractional accumulation saturates. Integer accumulation wraps. A synchronous clear empties the pipeline and zeroes the accumulator.

Top module: `mac_pipe`

## Requirements
- R1: While reset is asserted the accumulator reads 0, res_vld is 0 and iss_rdy is 1.
- R2: A halfword operation (iss_wide=0) is accepted on a rising edge where iss_vld and iss_rdy are high and clr is low. It uses opa[15:0] and opb[15:0]. With iss_fmt 00 or 11 they are signed integers. The updated accumulator and a res_vld pulse appear after the third rising edge, counting the accepting edge. Such operations may be accepted on consecutive edges.
- R3: With iss_fmt 01 the halfword operands are unsigned integers.
- R4: With iss_fmt 10 the halfword operands are signed Q1.15. The signed product is shifted left one bit to give a Q1.31 value.
- R5: In iss_fmt 10, 0x8000 times 0x8000 yields 0x7FFFFFFF.
- R6: With iss_acc=1 the product is added to the accumulator, wrapping modulo 2^32 in the integer formats and for full-word operations. With iss_acc=0 the product replaces the accumulator.
- R7: In iss_fmt 10 with iss_acc=1, the sum saturates to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R8: A full-word operation (iss_wide=1) uses all 32 bits of opa and opb. It ignores iss_fmt and yields the low 32 bits of the product. Its result and res_vld appear after the fifth rising edge, counting the accepting edge.
- R9: After a full-word operation is accepted, iss_rdy is low for exactly three cycles. Any iss_vld during that time is ignored.
- R10: res_vld is high for exactly one cycle per completed operation. While it is low, the accumulator holds its value except when clr acts.
- R11: clr=1 on a rising edge zeroes the accumulator and drops every in-flight operation, including one offered on that edge. After that edge res_vld is 0 and iss_rdy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of accumulator and pipeline |
| iss_vld | input | 1 | Operation offered |
| iss_wide | input | 1 | 1 = 32x32 operation, 0 = 16x16 operation |
| iss_fmt | input | 2 | 00/11 signed, 01 unsigned, 10 Q1.15 fraction |
| iss_acc | input | 1 | 1 = accumulate, 0 = load product |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| iss_rdy | output | 1 | Operation can be accepted |
| acc | output | 32 | Accumulator |
| res_vld | output | 1 | Accumulator updated by a completed operation |

## Verification
The bench sweeps corner halfword values (0, 1, the most positive and most negative numbers, all ones) through every format on back-to-back issues. A design that extended unsigned operands with the sign bit, or that let the upper operand halves leak in, would show up as wrong sums. Runs of fractional accumulation are driven past both saturation limits, and -1.0 times -1.0 is applied on its own. A design that wrapped there would return 0x80000000. Full-word operations on pseudo-random operands are mixed with halfword offers during the busy window. A design with a wrong partial-product shift, a wrong busy length or an accepted offer while busy would give wrong results or ready timing. A clear is applied while operations are in flight, and any stale result that survived it would show up on res_vld.

// File: rtl/mac_pipe.sv
`timescale 1ns/1ps
module mac_pipe #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          iss_vld,
  input  logic          iss_wide,
  input  logic [1:0]    iss_fmt,
  input  logic          iss_acc,
  input  logic [2*HW-1:0] opa,
  input  logic [2*HW-1:0] opb,
  output logic          iss_rdy,
  output logic [2*HW-1:0] acc,
  output logic          res_vld
);
  localparam int W = 2*HW;
  localparam logic [1:0] F_UINT = 2'd1;
  localparam logic [1:0] F_FRAC = 2'd2;
  localparam logic [1:0] K_N  = 2'd0;
  localparam logic [1:0] K_W0 = 2'd1;
  localparam logic [1:0] K_W1 = 2'd2;
  localparam logic [1:0] K_W2 = 2'd3;
  localparam logic [1:0] BUSY = 2'd3;
  localparam logic [W-1:0]  SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [HW-1:0] HMIN = {1'b1, {(HW-1){1'b0}}};

  logic [1:0]    cnt;
  logic [W-1:0]  ha, hb;
  logic          hacc;
  logic          s1_v, s1_sx, s1_frac, s1_acc;
  logic [1:0]    s1_k;
  logic [HW-1:0] s1_x, s1_y;
  logic          s2_v, s2_frac, s2_acc;
  logic [1:0]    s2_k;
  logic [W-1:0]  s2_p;
  logic [W-1:0]  t;
  logic [W-1:0]  ex, ey, mp, part;
  logic [W-1:0]  base, tsum, nacc;
  logic [W:0]    ssum;
  logic          take, fin;

  assign iss_rdy = (cnt == 2'd0);
  assign take    = iss_vld && iss_rdy && !clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; ha <= '0; hb <= '0; hacc <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
    end else if (take && iss_wide) begin
      cnt <= BUSY; ha <= opa; hb <= opb; hacc <= iss_acc;
    end else if (cnt != 2'd0) begin
      cnt <= cnt - 2'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sx <= 1'b0; s1_frac <= 1'b0; s1_acc <= 1'b0;
      s1_k <= K_N; s1_x <= '0; s1_y <= '0;
    end else if (clr) begin
      s1_v <= 1'b0;
    end else if (take) begin
      s1_v    <= 1'b1;
      s1_x    <= opa[HW-1:0];
      s1_y    <= opb[HW-1:0];
      s1_acc  <= iss_acc;
      s1_sx   <= !iss_wide && (iss_fmt != F_UINT);
      s1_frac <= !iss_wide && (iss_fmt == F_FRAC);
      s1_k    <= iss_wide ? K_W0 : K_N;
    end else if (cnt == BUSY) begin
      s1_v <= 1'b1; s1_x <= ha[W-1:HW]; s1_y <= hb[HW-1:0];
      s1_sx <= 1'b0; s1_frac <= 1'b0; s1_acc <= hacc; s1_k <= K_W1;
    end else if (cnt == BUSY - 2'd1) begin
      s1_v <= 1'b1; s1_x <= ha[HW-1:0]; s1_y <= hb[W-1:HW];
      s1_sx <= 1'b0; s1_frac <= 1'b0; s1_acc <= hacc; s1_k <= K_W2;
    end else begin
      s1_v <= 1'b0;
    end

  assign ex = {{HW{s1_sx & s1_x[HW-1]}}, s1_x};
  assign ey = {{HW{s1_sx & s1_y[HW-1]}}, s1_y};
  assign mp = ex * ey;

  always_comb begin
    case (s1_k)
      K_N:     part = !s1_frac ? mp :
                      (s1_x == HMIN && s1_y == HMIN) ? SMAX : {mp[W-2:0], 1'b0};
      K_W0:    part = mp;
      default: part = {mp[HW-1:0], {HW{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_v <= 1'b0; s2_frac <= 1'b0; s2_acc <= 1'b0; s2_k <= K_N; s2_p <= '0;
    end else if (clr) begin
      s2_v <= 1'b0;
    end else begin
      s2_v <= s1_v; s2_frac <= s1_frac; s2_acc <= s1_acc; s2_k <= s1_k; s2_p <= part;
    end

  assign base = s2_acc ? acc : '0;
  assign tsum = t + s2_p;
  assign ssum = {base[W-1], base} + {s2_p[W-1], s2_p};
  assign fin  = s2_v && (s2_k == K_N || s2_k == K_W2);

  always_comb begin
    nacc = acc;
    if (s2_k == K_N) begin
      if (!s2_frac)                   nacc = base + s2_p;
      else if (ssum[W] != ssum[W-1])  nacc = ssum[W] ? SMIN : SMAX;
      else                            nacc = ssum[W-1:0];
    end else if (s2_k == K_W2) begin
      nacc = base + tsum;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0; res_vld <= 1'b0; t <= '0;
    end else if (clr) begin
      acc <= '0; res_vld <= 1'b0; t <= '0;
    end else begin
      res_vld <= fin;
      if (fin) acc <= nacc;
      if (s2_v && s2_k == K_W0) t <= s2_p;
      if (s2_v && s2_k == K_W1) t <= tsum;
    end

  // R2
  narrow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && iss_rdy && !iss_wide && !clr) ##1 !clr ##1 !clr |=> res_vld);

  // R8
  wide_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && iss_rdy && iss_wide && !clr) ##1 !clr ##1 !clr ##1 !clr ##1 !clr |=> res_vld);

  // R9
  wide_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (iss_vld && iss_rdy && iss_wide) |=> !iss_rdy ##1 !iss_rdy ##1 !iss_rdy ##1 iss_rdy);

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_vld && !$past(clr)) |-> $stable(acc));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0 && !res_vld && iss_rdy));

  // R5
  frac_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_frac) |-> (s2_p != SMIN));
endmodule

// File: tb/test_mac_pipe.sv
`timescale 1ns/1ps
module test_mac_pipe;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic iss_vld = 1'b0, iss_wide = 1'b0, iss_acc = 1'b0;
  logic [1:0]  iss_fmt = 2'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        iss_rdy, res_vld;
  logic [31:0] acc;

  mac_pipe i_mac_pipe (
    .clk(clk), .rst_n(rst_n), .clr(clr), .iss_vld(iss_vld), .iss_wide(iss_wide),
    .iss_fmt(iss_fmt), .iss_acc(iss_acc), .opa(opa), .opb(opb),
    .iss_rdy(iss_rdy), .acc(acc), .res_vld(res_vld)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0, nerr = 0;
  int qt[$];
  logic [31:0] qv[$];
  logic [31:0] mdl = '0, vis = '0, seed = 32'h1234_5678;
  int rdy_from = 0, clr_at = -1;
  string req = "R2";
  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                            16'hFFFF, 16'h1234, 16'hFEDC, 16'h4000};

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  function automatic logic [31:0] nprod(logic [1:0] f, logic [31:0] a, logic [31:0] b);
    logic [15:0] x = a[15:0];
    logic [15:0] y = b[15:0];
    int sx = $signed(x);
    int sy = $signed(y);
    if (f == 2'd1) return {16'b0, x} * {16'b0, y};
    if (f == 2'd2) begin
      if (x == 16'h8000 && y == 16'h8000) return 32'h7FFF_FFFF;
      return (sx * sy) <<< 1;
    end
    return sx * sy;
  endfunction

  function automatic void upd(bit w, logic [1:0] f, bit ae, logic [31:0] a, logic [31:0] b);
    logic [31:0] p;
    longint s;
    if (w) begin
      p = a * b;
      mdl = ae ? mdl + p : p;
    end else begin
      p = nprod(f, a, b);
      if (f == 2'd2 && ae) begin
        s = longint'($signed(mdl)) + longint'($signed(p));
        if (s > 64'sd2147483647)       mdl = 32'h7FFF_FFFF;
        else if (s < -64'sd2147483648) mdl = 32'h8000_0000;
        else                           mdl = s[31:0];
      end else begin
        mdl = ae ? mdl + p : p;
      end
    end
  endfunction

  function automatic logic [31:0] nx(logic [31:0] s);
    logic [31:0] v = s;
    v = v ^ (v << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  task automatic observe();
    if (cyc == clr_at) vis = '0;
    if (qt.size() > 0 && qt[0] == cyc) begin
      chk(req, {31'b0, res_vld}, 32'd1);
      vis = qv.pop_front();
      void'(qt.pop_front());
      chk(req, acc, vis);
    end else begin
      chk("R10", {31'b0, res_vld}, 32'd0);
      chk("R10", acc, vis);
    end
    chk("R9", {31'b0, iss_rdy}, {31'b0, cyc >= rdy_from});
  endtask

  task automatic step(bit v, bit w, logic [1:0] f, bit ae, logic [31:0] a, logic [31:0] b, bit c);
    int e;
    @(negedge clk);
    observe();
    e = cyc + 1;
    if (c) begin
      qt.delete(); qv.delete(); mdl = '0; clr_at = e; rdy_from = e;
    end else if (v && cyc >= rdy_from) begin
      upd(w, f, ae, a, b);
      qt.push_back(e + (w ? 4 : 2));
      qv.push_back(mdl);
      if (w) rdy_from = e + 3;
    end
    clr = c; iss_vld = v; iss_wide = w; iss_fmt = f; iss_acc = ae; opa = a; opb = b;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 2'd0, 1'b0, '0, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", acc, 32'd0);
    chk("R1", {31'b0, res_vld}, 32'd0);
    chk("R1", {31'b0, iss_rdy}, 32'd1);
    rst_n = 1'b1;

    for (int f = 0; f < 4; f++) begin
      req = (f == 1) ? "R3" : (f == 2) ? "R4" : "R2";
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          step(1'b1, 1'b0, 2'(f), 1'((i + j) % 2),
               {16'hA5C3 ^ 16'(i), vals[i]}, {16'h5A3C ^ 16'(j), vals[j]}, 1'b0);
      idle(4);
    end

    req = "R5";
    step(1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_8000, 32'hFFFF_8000, 1'b0);
    step(1'b1, 1'b0, 2'd2, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0);
    idle(4);

    req = "R6";
    step(1'b1, 1'b0, 2'd1, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0);
    for (int k = 0; k < 3; k++)
      step(1'b1, 1'b0, 2'd1, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0);
    step(1'b1, 1'b0, 2'd0, 1'b0, 32'h0000_0003, 32'h0000_FFFE, 1'b0);
    idle(4);

    req = "R7";
    step(1'b1, 1'b0, 2'd2, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 1'b0);
    for (int k = 0; k < 3; k++)
      step(1'b1, 1'b0, 2'd2, 1'b1, 32'h0000_7FFF, 32'h0000_7FFF, 1'b0);
    for (int k = 0; k < 6; k++)
      step(1'b1, 1'b0, 2'd2, 1'b1, 32'h0000_8000, 32'h0000_7FFF, 1'b0);
    idle(4);

    req = "R8";
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a, b;
      seed = nx(seed); a = seed;
      seed = nx(seed); b = seed;
      step(1'b1, 1'(k % 3 != 2), 2'(k % 4), 1'(k % 2), a, b, 1'b0);
    end
    idle(6);

    req = "R11";
    step(1'b1, 1'b0, 2'd0, 1'b0, 32'h0000_0005, 32'h0000_0007, 1'b0);
    step(1'b1, 1'b0, 2'd0, 1'b1, 32'h0000_0002, 32'h0000_0003, 1'b0);
    step(1'b1, 1'b1, 2'd0, 1'b1, 32'h0001_0002, 32'h0003_0004, 1'b1);
    step(1'b0, 1'b0, 2'd0, 1'b0, '0, '0, 1'b0);
    chk("R11", acc, 32'd0);
    chk("R11", {31'b0, res_vld}, 32'd0);
    chk("R11", {31'b0, iss_rdy}, 32'd1);
    step(1'b1, 1'b1, 2'd0, 1'b0, 32'h0001_0002, 32'h0003_0004, 1'b0);
    step(1'b0, 1'b0, 2'd0, 1'b0, '0, '0, 1'b0);
    step(1'b0, 1'b0, 2'd0, 1'b0, '0, '0, 1'b1);
    idle(6);
    chk("R11", acc, 32'd0);
    step(1'b1, 1'b0, 2'd1, 1'b1, 32'h0000_0009, 32'h0000_0009, 1'b0);
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule